// File: doc/BRIEF.md
# Warp Divergence Mask Sequencer

This block manages the per-lane enable mask of a single warp of lanes as the warp meets a data-dependent branch. Before any branch, the warp receives a starting mask derived from the thread count of its block and its own warp index. A warp at the tail of a block whose size is not a whole number of warps therefore starts with only its low lanes enabled.

When a branch request arrives, every lane supplies the identifier of the target it wants to go to. The sequencer groups the enabled lanes by target and presents the groups one at a time as execution phases. Each phase carries its lane mask and the shared target. The consumer signals completion of each phase with a strobe. Once the last group finishes, the mask that was in force before the branch comes back, and a one-cycle reconvergence flag marks the event. Requests that arrive while phases remain are held off through a ready signal.

Top module: `warp_diverge_seq`

## Requirements
- R1: After reset, `active_mask` is zero, `phase_valid` and `reconv` are low, and `br_ready` is high.
- R2: An `init_valid` pulse while idle sets the warp mask so that lane l is enabled exactly when `init_warp*32 + l < init_count`. The lane index is the thread id ANDed with 31. For example, count 100 with warp 3 gives 0x0000000F, count 48 with warp 1 gives 0x0000FFFF, and count 1 with warp 0 gives only lane 0. The new mask shows on `active_mask` from the next cycle.
- R3: Every phase mask contains only lanes that were enabled before the branch. Lanes that were off stay off in every phase and after reconvergence.
- R4: When the enabled lanes name N distinct targets, exactly N phases are issued, one per cycle at most. Each phase holds all enabled lanes of one target, and `phase_target` carries that target. Phases are ordered by ascending lowest lane index. Lane l's target is `br_target[l*5 +: 5]`.
- R5: If all enabled lanes name the same target, one phase is issued whose mask equals the whole pre-branch mask.
- R6: With 32 distinct targets on a full warp, 32 phases are issued, each with exactly one bit set, in lanes 0 to 31 order.
- R7: On the cycle after the last phase is acknowledged, `reconv` is high for exactly one cycle. On that cycle `active_mask` equals the pre-branch mask and `br_ready` is high.
- R8: `br_ready` is low while a branch is in progress. A `br_valid` that arrives then is ignored and does not change the current phase.
- R9: `init_valid` while a branch is in progress is ignored. The mask restored at reconvergence is the pre-branch mask.
- R10: `phase_done` while no phase is valid has no effect. A phase stays stable until it is acknowledged.
- R11: A branch taken with an all-zero mask issues no phase and raises `reconv` on the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Load the starting mask |
| init_count | input | 16 | Thread count of the block |
| init_warp | input | 11 | Index of this warp within the block |
| br_valid | input | 1 | Branch request |
| br_ready | output | 1 | Sequencer can accept a branch |
| br_target | input | 160 | Target identifier per lane, 5 bits each |
| phase_done | input | 1 | Current phase has finished |
| phase_valid | output | 1 | A phase is being presented |
| phase_mask | output | 32 | Lanes of the current phase |
| phase_target | output | 5 | Target of the current phase |
| active_mask | output | 32 | Mask currently in force |
| reconv | output | 1 | One-cycle pulse at reconvergence |

## Verification
Several properties are checked on every cycle:
- Phase masks stay inside the pre-branch mask and are never empty while valid.
- Consecutive acknowledged phases share no lane.
- Ready is low whenever a phase is presented.
- An unacknowledged phase holds still.
- Reconvergence arrives only with ready high and no phase valid.

The directed scenarios are needed to show the parts that per-cycle properties cannot see. These are the exact tail-warp masks, the count and ascending order of phases for given target patterns, the restoration of the pre-branch mask, and the rejection of branch or init requests made while busy.

// File: rtl/warp_diverge_seq.sv
`timescale 1ns/1ps
module warp_diverge_seq #(
  parameter int LANES = 32,
  parameter int TW = 5,
  parameter int CW = 16,
  localparam int LW = $clog2(LANES),
  localparam int WW = CW - LW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_valid,
  input  logic [CW-1:0]       init_count,
  input  logic [WW-1:0]       init_warp,
  input  logic                br_valid,
  output logic                br_ready,
  input  logic [LANES*TW-1:0] br_target,
  input  logic                phase_done,
  output logic                phase_valid,
  output logic [LANES-1:0]    phase_mask,
  output logic [TW-1:0]       phase_target,
  output logic [LANES-1:0]    active_mask,
  output logic                reconv
);
  logic [LANES-1:0]    base_q, pend_q, init_mask, grp;
  logic [LANES*TW-1:0] tgt_q;
  logic                busy_q, reconv_q;
  logic [LW-1:0]       lead;
  logic [TW-1:0]       lead_tgt;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      init_mask[l] = ({init_warp, LW'(l)} < init_count);
  end

  always_comb begin
    lead = '0;
    for (int l = LANES-1; l >= 0; l--)
      if (pend_q[l]) lead = LW'(l);
  end

  assign lead_tgt = tgt_q[lead*TW +: TW];

  always_comb begin
    for (int l = 0; l < LANES; l++)
      grp[l] = pend_q[l] && (tgt_q[l*TW +: TW] == lead_tgt);
  end

  assign phase_valid  = busy_q && (|pend_q);
  assign phase_mask   = phase_valid ? grp : '0;
  assign phase_target = phase_valid ? lead_tgt : '0;
  assign br_ready     = !busy_q;
  assign reconv       = reconv_q;
  assign active_mask  = busy_q ? phase_mask : base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      pend_q   <= '0;
      tgt_q    <= '0;
      busy_q   <= 1'b0;
      reconv_q <= 1'b0;
    end else begin
      reconv_q <= 1'b0;
      if (!busy_q) begin
        if (init_valid) base_q <= init_mask;
        if (br_valid) begin
          tgt_q  <= br_target;
          pend_q <= init_valid ? init_mask : base_q;
          busy_q <= 1'b1;
        end
      end else if (!(|pend_q)) begin
        busy_q   <= 1'b0;
        reconv_q <= 1'b1;
      end else if (phase_done) begin
        pend_q <= pend_q & ~grp;
        if ((pend_q & ~grp) == '0) begin
          busy_q   <= 1'b0;
          reconv_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/warp_diverge_seq_chk.sv
`timescale 1ns/1ps
module warp_diverge_seq_chk #(parameter int LANES = 32) (
  input logic             clk,
  input logic             rst_n,
  input logic             phase_valid,
  input logic             phase_done,
  input logic [LANES-1:0] phase_mask,
  input logic [LANES-1:0] base_q,
  input logic             br_ready,
  input logic             reconv
);
  p_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |-> ((phase_mask & ~base_q) == '0));
  p_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |-> (phase_mask != '0));
  p_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid && phase_done) |=> (!phase_valid || ((phase_mask & $past(phase_mask)) == '0)));
  p_busy_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |-> !br_ready);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid && !phase_done) |=> (phase_valid && $stable(phase_mask)));
  p_reconv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reconv |-> (br_ready && !phase_valid));
  p_reconv_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reconv |=> !reconv);
endmodule

bind warp_diverge_seq warp_diverge_seq_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_valid(phase_valid), .phase_done(phase_done),
  .phase_mask(phase_mask), .base_q(base_q), .br_ready(br_ready), .reconv(reconv)
);

// File: tb/sim_warp_diverge_seq.sv
`timescale 1ns/1ps
module sim_warp_diverge_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic init_valid = 1'b0, br_valid = 1'b0, phase_done = 1'b0;
  logic [15:0] init_count = '0;
  logic [10:0] init_warp = '0;
  logic [159:0] br_target = '0;
  logic br_ready, phase_valid, reconv;
  logic [31:0] phase_mask, active_mask;
  logic [4:0] phase_target;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  warp_diverge_seq u0 (
    .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_count(init_count),
    .init_warp(init_warp), .br_valid(br_valid), .br_ready(br_ready),
    .br_target(br_target), .phase_done(phase_done), .phase_valid(phase_valid),
    .phase_mask(phase_mask), .phase_target(phase_target),
    .active_mask(active_mask), .reconv(reconv)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_init(input int cnt, input int wp, input logic [31:0] exp);
    @(negedge clk);
    init_valid = 1'b1; init_count = 16'(cnt); init_warp = 11'(wp);
    @(negedge clk);
    init_valid = 1'b0;
    chk(active_mask == exp, "R2 init mask", active_mask, exp);
  endtask

  task automatic run_branch(input logic [31:0] base, input logic [159:0] tg,
                            input int exp_phases, input string req);
    logic [31:0] pend, grp;
    logic [4:0] lt;
    int n, lo;
    pend = base; n = 0;
    @(negedge clk);
    chk(br_ready == 1'b1, "R8 ready idle", 32'(br_ready), 32'd1);
    br_valid = 1'b1; br_target = tg;
    @(negedge clk);
    br_valid = 1'b0;
    if (pend == '0) begin
      chk(phase_valid == 1'b0, "R11 no phase", 32'(phase_valid), 32'd0);
      @(negedge clk);
    end
    while (pend != '0) begin
      lo = 0;
      for (int l = 31; l >= 0; l--) if (pend[l]) lo = l;
      lt = tg[lo*5 +: 5];
      grp = '0;
      for (int l = 0; l < 32; l++) if (pend[l] && tg[l*5 +: 5] == lt) grp[l] = 1'b1;
      chk(phase_valid == 1'b1, {req, " phase valid"}, 32'(phase_valid), 32'd1);
      chk(phase_mask == grp, {req, " phase mask"}, phase_mask, grp);
      chk(phase_target == lt, {req, " phase target"}, 32'(phase_target), 32'(lt));
      phase_done = 1'b1;
      @(negedge clk);
      phase_done = 1'b0;
      pend = pend & ~grp;
      n++;
    end
    chk(n == exp_phases, {req, " phase count"}, 32'(n), 32'(exp_phases));
    chk(reconv == 1'b1, "R7 reconv pulse", 32'(reconv), 32'd1);
    chk(active_mask == base, "R7 R3 restored mask", active_mask, base);
    chk(br_ready == 1'b1, "R7 ready at reconv", 32'(br_ready), 32'd1);
    @(negedge clk);
    chk(reconv == 1'b0, "R7 reconv one cycle", 32'(reconv), 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(active_mask == '0, "R1 mask", active_mask, 32'd0);
    chk(phase_valid == 1'b0, "R1 phase_valid", 32'(phase_valid), 32'd0);
    chk(br_ready == 1'b1, "R1 br_ready", 32'(br_ready), 32'd1);
    chk(reconv == 1'b0, "R1 reconv", 32'(reconv), 32'd0);
  endtask

  task automatic t_init;
    do_init(100, 3, 32'h0000000F);
    do_init(48, 1, 32'h0000FFFF);
    do_init(1, 0, 32'h00000001);
    do_init(100, 4, 32'h00000000);
    do_init(64, 0, 32'hFFFFFFFF);
  endtask

  task automatic t_uniform;
    logic [159:0] tg;
    for (int l = 0; l < 32; l++) tg[l*5 +: 5] = 5'd7;
    do_init(32, 0, 32'hFFFFFFFF);
    run_branch(32'hFFFFFFFF, tg, 1, "R5 uniform");
  endtask

  task automatic t_even_odd;
    logic [159:0] tg;
    for (int l = 0; l < 32; l++) tg[l*5 +: 5] = (l % 2 == 0) ? 5'd3 : 5'd1;
    run_branch(32'hFFFFFFFF, tg, 2, "R4 two targets");
  endtask

  task automatic t_tail;
    logic [159:0] tg;
    for (int l = 0; l < 32; l++) tg[l*5 +: 5] = 5'd5;
    tg[0 +: 5] = 5'd9; tg[5 +: 5] = 5'd2; tg[10 +: 5] = 5'd9; tg[15 +: 5] = 5'd2;
    do_init(100, 3, 32'h0000000F);
    run_branch(32'h0000000F, tg, 2, "R3 tail warp");
  endtask

  task automatic t_single;
    logic [159:0] tg;
    for (int l = 0; l < 32; l++) tg[l*5 +: 5] = 5'(l);
    do_init(1, 0, 32'h00000001);
    run_branch(32'h00000001, tg, 1, "R3 single thread");
  endtask

  task automatic t_distinct;
    logic [159:0] tg;
    for (int l = 0; l < 32; l++) tg[l*5 +: 5] = 5'(31 - l);
    do_init(32, 0, 32'hFFFFFFFF);
    run_branch(32'hFFFFFFFF, tg, 32, "R6 distinct");
  endtask

  task automatic t_busy;
    logic [159:0] tg, tg2;
    for (int l = 0; l < 32; l++) begin
      tg[l*5 +: 5] = (l < 16) ? 5'd4 : 5'd8;
      tg2[l*5 +: 5] = 5'(l);
    end
    do_init(32, 0, 32'hFFFFFFFF);
    @(negedge clk);
    br_valid = 1'b1; br_target = tg;
    @(negedge clk);
    br_target = tg2;
    chk(br_ready == 1'b0, "R8 ready low busy", 32'(br_ready), 32'd0);
    init_valid = 1'b1; init_count = 16'd1; init_warp = '0;
    @(negedge clk);
    br_valid = 1'b0; init_valid = 1'b0;
    chk(phase_mask == 32'h0000FFFF, "R8 phase unchanged", phase_mask, 32'h0000FFFF);
    chk(phase_target == 5'd4, "R8 target unchanged", 32'(phase_target), 32'd4);
    phase_done = 1'b1;
    @(negedge clk);
    chk(phase_mask == 32'hFFFF0000, "R8 second phase", phase_mask, 32'hFFFF0000);
    @(negedge clk);
    phase_done = 1'b0;
    chk(reconv == 1'b1, "R9 reconv", 32'(reconv), 32'd1);
    chk(active_mask == 32'hFFFFFFFF, "R9 init ignored busy", active_mask, 32'hFFFFFFFF);
  endtask

  task automatic t_done_idle;
    @(negedge clk);
    phase_done = 1'b1;
    @(negedge clk);
    phase_done = 1'b0;
    chk(active_mask == 32'hFFFFFFFF, "R10 mask kept", active_mask, 32'hFFFFFFFF);
    chk(reconv == 1'b0, "R10 no reconv", 32'(reconv), 32'd0);
    chk(phase_valid == 1'b0, "R10 no phase", 32'(phase_valid), 32'd0);
  endtask

  task automatic t_zero;
    logic [159:0] tg;
    tg = '0;
    do_init(100, 4, 32'h00000000);
    run_branch(32'h00000000, tg, 0, "R11 empty warp");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_init();
    t_uniform();
    t_even_odd();
    t_tail();
    t_single();
    t_distinct();
    t_busy();
    t_done_idle();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule